// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Hub

This block joins several two-wire serial bus segments, each with a clock and a data line, into one logical bus. When an external device pulls a line low on any connected segment, the hub pulls the same line low on every other connected segment. The clock and data lines are handled separately. The hub samples each segment line through a synchronizer on the system clock and drives each line through its own open-drain pull-down enable. Masters and slaves may sit on any segment, and any segment can reach any other through a single stage of logic.

Segment 0 is always connected. Every other segment has an active-high connect request. The hub follows the bus through START and STOP conditions, and it applies a change to a connect request only while the bus is idle and that segment's own lines are both high. Lock-up is avoided by tracking which segments hold a line low by their own devices. A segment the hub is pulling low, or released only a few cycles ago, never counts as a new source. The hub therefore never echoes a low back to the segment it came from. A device that keeps a line low while the hub is also pulling it, as in clock stretching, becomes the new source once the first source lets go.

Top module: `twowire_hub`

## Requirements
- R1: After reset, all pull-down outputs are off, `bus_busy` is 0 and `en_active` is all ones (every switchable segment connected).
- R2: An external low on a line of a connected segment turns on the pull-down of that same line on every other connected segment within 4 clock cycles.
- R3: While a segment's `en_active` bit is 0, its pull-downs stay off and its line inputs have no effect on any output.
- R4: When the only source releases a line, all pull-downs of that line turn off within 4 cycles. They stay off while no external device pulls the line low, so there is no echo.
- R5: The hub never turns on the pull-down of a line on a segment that is a source for that line. At any time, at least one connected segment's pull-down on each line is off.
- R6: If a second connected segment is held low externally while the hub drives it, and the first source then releases, that segment becomes the source within 8 cycles. Every other connected segment, including the first, is pulled low again until it releases.
- R7: The bus state is the wired-AND of the connected segments. A falling data line while the clock is high sets `bus_busy`. A rising data line while the clock is high clears it.
- R8: A change on `en_req[p]` reaches `en_active[p]` only in a cycle where the bus is idle and segment p's synchronized clock and data lines are both high. While `bus_busy` is 1, `en_active` does not change.
- R9: The clock and data lines are independent: a low on one line never turns on a pull-down of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | NUM_PORTS | Sensed clock line level of each segment (bit p = segment p) |
| sda_in | input | NUM_PORTS | Sensed data line level of each segment |
| en_req | input | NUM_PORTS-1 | Connect request for segments 1 and up, index p = segment p, active high |
| scl_pd | output | NUM_PORTS | Clock line pull-down enable per segment (1 = drive low) |
| sda_pd | output | NUM_PORTS | Data line pull-down enable per segment |
| en_active | output | NUM_PORTS-1 | Connect state currently in force for segments 1 and up |
| bus_busy | output | 1 | 1 between a START and the following STOP |

## Verification
The bench builds the hub with the default five segments, a two-stage synchronizer and one cycle of release grace, which makes the source mask three cycles long. Five segments make room for every source position, for random subsets of disconnected segments and for a handover in which a third, uninvolved segment must follow the new source. The two-stage synchronizer places the stale low reading after a release inside the mask window. Over the sequence, a wrong mask length in either direction would appear as an echo or as a missed handover.

// File: rtl/hub_pkg.sv
package hub_pkg;
   // Line index inside the per-line arrays of the hub.
   typedef enum logic {
      LN_CLK = 1'b0,
      LN_DAT = 1'b1
   } hub_line_e;

   localparam int unsigned HUB_LINES = 2;

   // Width of the saturating counters used by the checker.
   localparam int unsigned HUB_CNT_W = 8;
endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int FLOPS = STAGES * WIDTH;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("hub_sync: WIDTH must be at least 1");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q <= {FLOPS{RST_LVL}};
            end else begin
               st_q[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  st_q[i] <= st_q[i-1];
               end
            end
         end
         assign q = st_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hub_line.sv
module hub_line #(
   parameter int PORTS    = 5,
   parameter int MASK_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PORTS-1:0] lvl,   // synchronized line level per segment
   input  logic [PORTS-1:0] en,    // segment connected
   output logic [PORTS-1:0] pd     // pull-down enable per segment
);
   logic [PORTS-1:0] pd_q;
   logic [PORTS-1:0] masked;
   logic [PORTS-1:0] src_set;
   logic [PORTS-1:0][MASK_LEN-1:0] hist_q;

   generate
      if (MASK_LEN < 1) begin : g_bad_mask
         $error("hub_line: MASK_LEN must be at least 1");
      end
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         if (MASK_LEN == 1) begin : g_hist1
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) hist_q[p] <= '0;
               else        hist_q[p] <= pd_q[p];
            end
         end else begin : g_histn
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) hist_q[p] <= '0;
               else        hist_q[p] <= {hist_q[p][MASK_LEN-2:0], pd_q[p]};
            end
         end
         // A segment the hub drives, or released within the window, is not a source.
         assign masked[p] = pd_q[p] | (|hist_q[p]);
      end
   endgenerate

   // Segments held low by their own devices.
   assign src_set = en & ~lvl & ~masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q <= '0;
      end else if (|src_set) begin
         pd_q <= en & ~src_set;
      end else begin
         pd_q <= '0;
      end
   end

   assign pd = pd_q;
endmodule

// File: rtl/hub_idle.sv
module hub_idle #(
   parameter int PORTS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PORTS-1:0] scl_s,
   input  logic [PORTS-1:0] sda_s,
   input  logic [PORTS-1:1] req_s,
   output logic [PORTS-1:1] en_act,
   output logic             busy
);
   logic [PORTS-1:1] en_q;
   logic [PORTS-1:0] en_all;
   logic scl_bus, sda_bus;
   logic scl_prev_q, sda_prev_q, busy_q;
   logic start_c, stop_c;

   assign en_all  = {en_q, 1'b1};
   assign scl_bus = &(scl_s | ~en_all);
   assign sda_bus = &(sda_s | ~en_all);

   assign start_c = scl_bus & scl_prev_q &  sda_prev_q & ~sda_bus;
   assign stop_c  = scl_bus & scl_prev_q & ~sda_prev_q &  sda_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev_q <= 1'b1;
         sda_prev_q <= 1'b1;
         busy_q     <= 1'b0;
      end else begin
         scl_prev_q <= scl_bus;
         sda_prev_q <= sda_bus;
         if (start_c)     busy_q <= 1'b1;
         else if (stop_c) busy_q <= 1'b0;
      end
   end

   generate
      for (genvar p = 1; p < PORTS; p++) begin : g_en
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q[p] <= 1'b1;
            end else if (!busy_q && !start_c && scl_s[p] && sda_s[p]) begin
               en_q[p] <= req_s[p];
            end
         end
      end
   endgenerate

   assign en_act = en_q;
   assign busy   = busy_q;
endmodule

// File: rtl/twowire_hub.sv
module twowire_hub #(
   parameter int NUM_PORTS    = 5,
   parameter int SYNC_STAGES  = 2,
   parameter int GRACE_CYCLES = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] scl_in,
   input  logic [NUM_PORTS-1:0] sda_in,
   input  logic [NUM_PORTS-1:1] en_req,
   output logic [NUM_PORTS-1:0] scl_pd,
   output logic [NUM_PORTS-1:0] sda_pd,
   output logic [NUM_PORTS-1:1] en_active,
   output logic                 bus_busy
);
   import hub_pkg::*;

   localparam int MASK_LEN = SYNC_STAGES + GRACE_CYCLES;
   localparam int SYNC_W   = 3 * NUM_PORTS - 1;

   generate
      if (NUM_PORTS < 2) begin : g_bad_ports
         $error("twowire_hub: NUM_PORTS must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("twowire_hub: SYNC_STAGES must be at least 1");
      end
      if (GRACE_CYCLES < 0) begin : g_bad_grace
         $error("twowire_hub: GRACE_CYCLES must not be negative");
      end
   endgenerate

   logic [NUM_PORTS-1:0] scl_s, sda_s;
   logic [NUM_PORTS-1:1] req_s;
   logic [NUM_PORTS-1:1] en_q;
   logic [NUM_PORTS-1:0] en_all;
   logic [HUB_LINES-1:0][NUM_PORTS-1:0] lvl_v, pd_v;

   hub_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES),
      .RST_LVL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({en_req, sda_in, scl_in}),
      .q    ({req_s, sda_s, scl_s})
   );

   hub_idle #(
      .PORTS(NUM_PORTS)
   ) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (scl_s),
      .sda_s (sda_s),
      .req_s (req_s),
      .en_act(en_q),
      .busy  (bus_busy)
   );

   assign en_all = {en_q, 1'b1};
   assign lvl_v[int'(LN_CLK)] = scl_s;
   assign lvl_v[int'(LN_DAT)] = sda_s;

   generate
      for (genvar ln = 0; ln < HUB_LINES; ln++) begin : g_line
         hub_line #(
            .PORTS   (NUM_PORTS),
            .MASK_LEN(MASK_LEN)
         ) u_line (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl_v[ln]),
            .en   (en_all),
            .pd   (pd_v[ln])
         );
      end
   endgenerate

   assign scl_pd    = pd_v[int'(LN_CLK)];
   assign sda_pd    = pd_v[int'(LN_DAT)];
   assign en_active = en_q;
endmodule

// File: rtl/hub_checker.sv
module hub_checker #(
   parameter int NUM_PORTS   = 5,
   parameter int SYNC_STAGES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PORTS-1:0] scl_in,
   input logic [NUM_PORTS-1:0] sda_in,
   input logic [NUM_PORTS-1:0] scl_pd,
   input logic [NUM_PORTS-1:0] sda_pd,
   input logic [NUM_PORTS-1:1] en_active,
   input logic                 bus_busy
);
   import hub_pkg::*;

   localparam int QUIET_LIM = SYNC_STAGES + 2;

   logic [NUM_PORTS-1:0] en_all;
   logic [HUB_CNT_W-1:0] scl_hi_q, sda_hi_q;

   assign en_all = {en_active, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_hi_q <= '0;
         sda_hi_q <= '0;
      end else begin
         if (!(&scl_in))             scl_hi_q <= '0;
         else if (!(&scl_hi_q))      scl_hi_q <= scl_hi_q + 1'b1;
         if (!(&sda_in))             sda_hi_q <= '0;
         else if (!(&sda_hi_q))      sda_hi_q <= sda_hi_q + 1'b1;
      end
   end

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((scl_pd | sda_pd) & ~en_all) == '0);                           // R3

   AST_SOURCE_UNDRIVEN_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_pd & en_all) != en_all);                                   // R5

   AST_SOURCE_UNDRIVEN_DAT: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pd & en_all) != en_all);                                   // R5

   AST_ENABLE_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy |=> $stable(en_active));                               // R8

   AST_RELEASE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_hi_q >= HUB_CNT_W'(QUIET_LIM)) |-> (scl_pd == '0));        // R4

   AST_RELEASE_DAT: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_hi_q >= HUB_CNT_W'(QUIET_LIM)) |-> (sda_pd == '0));        // R4
endmodule

bind twowire_hub hub_checker #(
   .NUM_PORTS  (NUM_PORTS),
   .SYNC_STAGES(SYNC_STAGES)
) u_hub_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_in   (scl_in),
   .sda_in   (sda_in),
   .scl_pd   (scl_pd),
   .sda_pd   (sda_pd),
   .en_active(en_active),
   .bus_busy (bus_busy)
);

// File: tb/sim_twowire_hub.sv
module sim_twowire_hub;
   localparam int N          = 5;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] ext_scl = '0;
   logic [N-1:0] ext_sda = '0;
   logic [N-1:1] en_req = '1;
   logic [N-1:0] scl_line, sda_line;
   logic [N-1:0] scl_pd, sda_pd;
   logic [N-1:1] en_active;
   logic bus_busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // wired-AND segments: low when an external device or the hub pulls
   assign scl_line = ~(ext_scl | scl_pd);
   assign sda_line = ~(ext_sda | sda_pd);

   always #(CLK_PERIOD/2) clk = ~clk;

   twowire_hub #(.NUM_PORTS(N), .SYNC_STAGES(2), .GRACE_CYCLES(1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .scl_in(scl_line), .sda_in(sda_line), .en_req(en_req),
      .scl_pd(scl_pd), .sda_pd(sda_pd),
      .en_active(en_active), .bus_busy(bus_busy)
   );

   function automatic logic [N-1:0] exp_drive(input logic [N-1:0] en_full, input int src);
      logic [N-1:0] one = 1;
      if (!en_full[src]) return '0;
      return en_full & ~(one << src);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [N-1:1] mask;
      logic [N-1:0] efull;
      void'($urandom(32'h0051_7E4D));

      cyc(4);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 clk pd", 32'(scl_pd), 32'h0);
      chk("R1 dat pd", 32'(sda_pd), 32'h0);
      chk("R1 enables", 32'(en_active), 32'hF);
      chk("R1 busy", 32'(bus_busy), 32'h0);

      // R2 / R9: clock low on segment 0
      ext_scl[0] = 1'b1;
      cyc(5);
      chk("R2 clk spread", 32'(scl_pd), 32'h1E);
      chk("R9 dat untouched", 32'(sda_pd), 32'h0);
      ext_scl[0] = 1'b0;
      cyc(5);
      chk("R4 release", 32'(scl_pd), 32'h0);
      cyc(10);
      chk("R4 no echo", 32'(scl_pd), 32'h0);

      // R2 / R7: data low on segment 2 while clock high = START
      ext_sda[2] = 1'b1;
      cyc(5);
      chk("R2 dat spread", 32'(sda_pd), 32'h1B);
      chk("R7 start", 32'(bus_busy), 32'h1);
      ext_sda[2] = 1'b0;
      cyc(8);
      chk("R4 dat release", 32'(sda_pd), 32'h0);
      chk("R7 stop", 32'(bus_busy), 32'h0);

      // R6: clock stretching handover from segment 0 to segment 3
      ext_scl[0] = 1'b1;
      cyc(5);
      ext_scl[3] = 1'b1;
      cyc(5);
      chk("R5 source undriven", 32'(scl_pd), 32'h1E);
      ext_scl[0] = 1'b0;
      cyc(10);
      chk("R6 handover", 32'(scl_pd), 32'h17);
      cyc(5);
      chk("R6 held", 32'(scl_pd), 32'h17);
      ext_scl[3] = 1'b0;
      cyc(10);
      chk("R4 after handover", 32'(scl_pd), 32'h0);

      // R8: enable change deferred while busy
      ext_sda[0] = 1'b1;
      cyc(6);
      chk("R7 busy", 32'(bus_busy), 32'h1);
      en_req[2] = 1'b0;
      cyc(10);
      chk("R8 deferred", 32'(en_active), 32'hF);
      ext_sda[0] = 1'b0;
      cyc(10);
      chk("R7 idle", 32'(bus_busy), 32'h0);
      chk("R8 applied", 32'(en_active), 32'hD);

      // R3: disconnected segment 2
      ext_scl[0] = 1'b1;
      cyc(5);
      chk("R3 not driven", 32'(scl_pd), 32'h1A);
      ext_scl[0] = 1'b0;
      cyc(8);
      ext_scl[2] = 1'b1;
      ext_sda[2] = 1'b1;
      cyc(6);
      chk("R3 clk ignored", 32'(scl_pd), 32'h0);
      chk("R3 dat ignored", 32'(sda_pd), 32'h0);
      chk("R3 no start", 32'(bus_busy), 32'h0);
      ext_scl[2] = 1'b0;
      ext_sda[2] = 1'b0;
      cyc(4);
      en_req[2] = 1'b1;
      cyc(6);
      chk("R8 reconnect", 32'(en_active), 32'hF);

      // random single-source rounds
      for (int r = 0; r < 60; r++) begin
         int src;
         int ln;
         mask = N'($urandom) >> 1;
         en_req = mask;
         cyc(8);
         chk("R8 random enable", 32'(en_active), 32'(mask));
         efull = {mask, 1'b1};
         src = int'($urandom % N);
         ln  = int'($urandom % 2);
         if (ln == 0) ext_scl[src] = 1'b1;
         else         ext_sda[src] = 1'b1;
         cyc(6 + int'($urandom % 5));
         if (ln == 0) begin
            chk("R2 random clk", 32'(scl_pd), 32'(exp_drive(efull, src)));
            chk("R9 random dat", 32'(sda_pd), 32'h0);
         end else begin
            chk("R2 random dat", 32'(sda_pd), 32'(exp_drive(efull, src)));
            chk("R9 random clk", 32'(scl_pd), 32'h0);
         end
         ext_scl = '0;
         ext_sda = '0;
         cyc(8);
         chk("R4 random release", 32'({scl_pd, sda_pd}), 32'h0);
         chk("R7 random idle", 32'(bus_busy), 32'h0);
      end

      finish_run();
   end
endmodule